// File: doc/BRIEF.md
# FP4 Block Dequantizer with Two-Level Scaling

This unit expands packed 4-bit floating-point element codes into IEEE-754 single-precision words. Each input transfer carries a group of sixteen element codes in the 1-sign, 2-exponent, 1-mantissa layout, together with one 8-bit block scale coded with a 4-bit exponent and a 3-bit mantissa. A second, per-tensor scale in single precision sits in a configuration register. That scale stays constant while the blocks of one tensor stream through.

For every block the unit emits one wide output beat of sixteen single-precision results. Each result is the element value times the block scale, and that product times the tensor scale, with one rounding step. Both the input and the output use valid/ready handshakes. The output may stall for any length of time, and the stall propagates back to the input. The tensor scale can only change while no block is inside the unit.

Top module: `fp4blk_dequant`

## Requirements
- R1: Lane i takes its code from `in_codes[4i+3:4i]` and drives its result on `out_data[32i+31:32i]`. Within a code, bit 3 is the sign, bits 2:1 the exponent (bias 1, 0 means subnormal) and bit 0 the mantissa, so the low three bits 0..7 give magnitudes 0, 0.5, 1, 1.5, 2, 3, 4, 6.
- R2: The block scale `in_scale` decodes with bit 7 as the sign, bits 6:3 as the exponent (bias 7) and bits 2:0 as the mantissa. An exponent of 0 gives mantissa/8 * 2^-6. There is no infinity encoding.
- R3: Each result is the single-precision round-to-nearest-even of (element * block scale) * tensor scale, with exactly one rounding.
- R4: A block scale with bits 6:0 all ones (0x7F or 0xFF) makes all sixteen lanes 0x7FC00000. A NaN tensor scale, or an infinite tensor scale times a zero product, gives the same result.
- R5: The sign of a result is the XOR of the element, block and tensor signs. Code 0x8 with positive scales gives 0x80000000.
- R6: Results whose magnitude reaches 2^128 after rounding become signed infinity. Results below 2^-126 after rounding become signed zero. A subnormal tensor scale acts as zero.
- R7: A block accepted at a rising edge appears with `out_valid` high after the next rising edge, one output beat per block.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold and `in_ready` is low.
- R9: A tensor-scale write (`cfg_valid` and `cfg_ready` high) happens only when no block is in the unit. While `cfg_valid` is high, `in_ready` is low. Blocks already accepted use the old scale.
- R10: After reset `out_valid` is low, `in_ready` and `cfg_ready` are high, and the tensor scale is 1.0 (0x3F800000).
- R11: With `out_ready` held high, blocks are accepted on consecutive cycles and leave in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Tensor-scale write request |
| cfg_scale | input | 32 | New tensor scale, single precision |
| cfg_ready | output | 1 | Write is taken this cycle (unit empty) |
| in_valid | input | 1 | Block present on the input |
| in_codes | input | 64 | Sixteen packed 4-bit element codes |
| in_scale | input | 8 | Block scale, 8-bit float |
| in_ready | output | 1 | Block is taken this cycle |
| out_valid | output | 1 | Result beat present |
| out_data | output | 512 | Sixteen single-precision results |
| out_ready | input | 1 | Consumer takes the beat |

## Verification
The hardest situation to reach is a tensor-scale write that collides with a block still held in the output stage. The stimulus creates it by lowering `out_ready` and sending one block. It then raises `cfg_valid` while that beat is parked, so the write must wait and the parked beat must still show the old scale. Rounding ties, overflow to infinity and flush to zero come from tensor scales picked near the edges of the single-precision range, each combined with every element code.

// File: rtl/fp4dq_pkg.sv
package fp4dq_pkg;

  localparam int unsigned CODE_W  = 4;
  localparam int unsigned SCALE_W = 8;
  localparam int unsigned WORD_W  = 32;
  localparam logic [31:0] QNAN_W  = 32'h7FC0_0000;
  localparam logic [31:0] ONE_W   = 32'h3F80_0000;

  // 4-bit element code to single precision (exact)
  function automatic logic [31:0] elem_to_f32(input logic [3:0] c);
    logic [7:0] ex;
    if (c[2:1] == 2'd0) begin
      if (c[0]) return {c[3], 8'd126, 23'd0};
      return {c[3], 31'd0};
    end
    ex = 8'd126 + {6'd0, c[2:1]};
    return {c[3], ex, c[0], 22'd0};
  endfunction

  function automatic logic scale_is_nan(input logic [7:0] s);
    return (s[6:0] == 7'h7F);
  endfunction

  // 8-bit block scale (bias 7) to single precision (exact)
  function automatic logic [31:0] scale_to_f32(input logic [7:0] s);
    logic [7:0] ex;
    if (scale_is_nan(s)) return QNAN_W;
    if (s[6:3] == 4'd0) begin
      if (s[2]) return {s[7], 8'd120, s[1:0], 21'd0};
      if (s[1]) return {s[7], 8'd119, s[0], 22'd0};
      if (s[0]) return {s[7], 8'd118, 23'd0};
      return {s[7], 31'd0};
    end
    ex = 8'd120 + {4'd0, s[6:3]};
    return {s[7], ex, s[2:0], 20'd0};
  endfunction

  // single-precision multiply, nearest-even, flushes subnormals
  function automatic logic [31:0] f32_mul(input logic [31:0] a, input logic [31:0] b);
    logic        sg, an, bn, ai, bi, az, bz, grd, stk, rnd;
    logic [47:0] prod;
    logic [23:0] mant;
    logic [24:0] mr;
    int          ex;
    sg = a[31] ^ b[31];
    an = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
    bn = (b[30:23] == 8'hFF) && (b[22:0] != 23'd0);
    ai = (a[30:23] == 8'hFF) && (a[22:0] == 23'd0);
    bi = (b[30:23] == 8'hFF) && (b[22:0] == 23'd0);
    az = (a[30:23] == 8'h00);
    bz = (b[30:23] == 8'h00);
    if (an || bn || (ai && bz) || (bi && az)) return QNAN_W;
    if (ai || bi) return {sg, 8'hFF, 23'd0};
    if (az || bz) return {sg, 31'd0};
    prod = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
    ex   = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (prod[47]) begin
      mant = prod[47:24];
      grd  = prod[23];
      stk  = |prod[22:0];
      ex   = ex + 1;
    end else begin
      mant = prod[46:23];
      grd  = prod[22];
      stk  = |prod[21:0];
    end
    rnd = grd & (stk | mant[0]);
    mr  = {1'b0, mant} + {24'd0, rnd};
    if (mr[24]) begin
      mr = mr >> 1;
      ex = ex + 1;
    end
    if (ex >= 255) return {sg, 8'hFF, 23'd0};
    if (ex <= 0) return {sg, 31'd0};
    return {sg, ex[7:0], mr[22:0]};
  endfunction

endpackage

// File: rtl/fp4dq_cfg.sv
module fp4dq_cfg
  import fp4dq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic [31:0] cfg_scale,
  input  logic        pipe_busy,
  output logic        cfg_ready,
  output logic [31:0] tscale
);

  logic cfg_fire;

  assign cfg_ready = ~pipe_busy;
  assign cfg_fire  = cfg_valid & cfg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tscale <= ONE_W;
    else if (cfg_fire) tscale <= cfg_scale;
  end

  // R9
  tscale_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_busy |=> $stable(tscale));

endmodule

// File: rtl/fp4dq_ctrl.sv
module fp4dq_ctrl
  import fp4dq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_scale,
  input  logic        out_ready,
  input  logic        cfg_valid,
  output logic        in_ready,
  output logic        out_valid,
  output logic        adv,
  output logic        pipe_busy,
  output logic [31:0] bscale_f32,
  output logic        s1_nan_valid
);

  logic v1, v2, s1_nan, in_fire;

  assign adv          = ~v2 | out_ready;
  assign in_ready     = adv & ~cfg_valid;
  assign in_fire      = in_valid & in_ready;
  assign out_valid    = v2;
  assign pipe_busy    = v1 | v2;
  assign bscale_f32   = scale_to_f32(in_scale);
  assign s1_nan_valid = v1 & s1_nan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      v2     <= 1'b0;
      s1_nan <= 1'b0;
    end else if (adv) begin
      v1     <= in_fire;
      v2     <= v1;
      s1_nan <= scale_is_nan(in_scale);
    end
  end

  // R8
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R8
  no_accept_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (!out_valid || out_ready));
  // R9
  cfg_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !cfg_valid);
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && adv) |=> out_valid);

endmodule

// File: rtl/fp4dq_lane.sv
module fp4dq_lane
  import fp4dq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic [3:0]  code,
  input  logic [31:0] bscale_f32,
  input  logic [31:0] tscale,
  output logic [31:0] out_word
);

  logic [31:0] part_q;
  logic [31:0] part_d;
  logic [31:0] res_d;

  assign part_d = f32_mul(elem_to_f32(code), bscale_f32);
  assign res_d  = f32_mul(part_q, tscale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q   <= '0;
      out_word <= '0;
    end else if (adv) begin
      part_q   <= part_d;
      out_word <= res_d;
    end
  end

  // R8
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(out_word));

endmodule

// File: rtl/fp4blk_dequant.sv
module fp4blk_dequant
  import fp4dq_pkg::*;
#(
  parameter int unsigned LANES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_valid,
  input  logic [31:0]              cfg_scale,
  output logic                     cfg_ready,
  input  logic                     in_valid,
  input  logic [LANES*CODE_W-1:0]  in_codes,
  input  logic [SCALE_W-1:0]       in_scale,
  output logic                     in_ready,
  output logic                     out_valid,
  output logic [LANES*WORD_W-1:0]  out_data,
  input  logic                     out_ready
);

  localparam int unsigned OUT_W = LANES * WORD_W;

  logic        adv, pipe_busy, s1_nan_valid;
  logic [31:0] bscale_f32, tscale;

  fp4dq_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_scale(in_scale),
    .out_ready(out_ready), .cfg_valid(cfg_valid), .in_ready(in_ready),
    .out_valid(out_valid), .adv(adv), .pipe_busy(pipe_busy),
    .bscale_f32(bscale_f32), .s1_nan_valid(s1_nan_valid)
  );

  fp4dq_cfg cfg_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_scale(cfg_scale),
    .pipe_busy(pipe_busy), .cfg_ready(cfg_ready), .tscale(tscale)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fp4dq_lane lane_i (
      .clk(clk), .rst_n(rst_n), .adv(adv),
      .code(in_codes[g*CODE_W +: CODE_W]),
      .bscale_f32(bscale_f32), .tscale(tscale),
      .out_word(out_data[g*WORD_W +: WORD_W])
    );
  end

  // R4
  nan_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_nan_valid) |=> (out_data == {LANES{QNAN_W}}));
  // R8
  beat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data));

  logic [OUT_W-1:0] unused_w;
  assign unused_w = out_data;

endmodule

// File: tb/fp4blk_dequant_tb_top.sv
`timescale 1ns/1ps
module fp4blk_dequant_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_valid = 1'b0;
  logic [31:0]  cfg_scale = '0;
  logic         cfg_ready;
  logic         in_valid = 1'b0;
  logic [63:0]  in_codes = '0;
  logic [7:0]   in_scale = '0;
  logic         in_ready;
  logic         out_valid;
  logic [511:0] out_data;
  logic         out_ready = 1'b1;

  int nchk = 0;
  int nfail = 0;
  logic [31:0] cur_ts = 32'h3F80_0000;

  localparam logic [63:0] SEQ = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] REV = 64'h0123_4567_89AB_CDEF;

  // {tensor scale, block scale}
  localparam logic [39:0] TV [15] = '{
    {32'h3F80_0000, 8'h38}, {32'h3F80_0000, 8'h00}, {32'h3F80_0000, 8'h01},
    {32'h4040_0000, 8'h07}, {32'h3F80_0000, 8'h7E}, {32'h3F80_0000, 8'h7F},
    {32'h3F80_0000, 8'hFF}, {32'h3FC0_0000, 8'hB8}, {32'h3DCC_CCCD, 8'h3D},
    {32'h7F00_0000, 8'h56}, {32'h0080_0000, 8'h08}, {32'h3F7F_FFFF, 8'h41},
    {32'h7F80_0000, 8'h38}, {32'h0040_0000, 8'h38}, {32'hBF00_0001, 8'h4B}
  };

  always #2.5 clk = ~clk;

  fp4blk_dequant dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_scale(cfg_scale),
    .cfg_ready(cfg_ready), .in_valid(in_valid), .in_codes(in_codes),
    .in_scale(in_scale), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  function automatic real p2(input int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else for (int i = 0; i < -e; i++) r = r / 2.0;
    return r;
  endfunction

  // independent real-number reference
  function automatic logic [31:0] model(input logic [3:0] c, input logic [7:0] s, input logic [31:0] t);
    real em, bm, tm, mag, m, f, fr;
    int e;
    logic sg;
    logic [24:0] ip;
    if (s[6:0] == 7'h7F) return 32'h7FC0_0000;
    if (t[30:23] == 8'hFF && t[22:0] != 0) return 32'h7FC0_0000;
    case (c[2:0])
      3'd0: em = 0.0;  3'd1: em = 0.5; 3'd2: em = 1.0; 3'd3: em = 1.5;
      3'd4: em = 2.0;  3'd5: em = 3.0; 3'd6: em = 4.0; default: em = 6.0;
    endcase
    if (s[6:3] == 0) bm = real'(s[2:0]) / 8.0 * p2(-6);
    else bm = (1.0 + real'(s[2:0]) / 8.0) * p2(int'(s[6:3]) - 7);
    sg = c[3] ^ s[7] ^ t[31];
    if (t[30:23] == 8'hFF) begin
      if (em * bm == 0.0) return 32'h7FC0_0000;
      return {sg, 8'hFF, 23'd0};
    end
    if (t[30:23] == 0) tm = 0.0;
    else tm = (1.0 + real'(t[22:0]) / 8388608.0) * p2(int'(t[30:23]) - 127);
    mag = em * bm * tm;
    if (mag == 0.0) return {sg, 31'd0};
    m = mag; e = 0;
    while (m >= 2.0) begin m = m / 2.0; e++; end
    while (m < 1.0) begin m = m * 2.0; e--; end
    f = m * 8388608.0;
    ip = 25'($rtoi(f));
    fr = f - real'(ip);
    if (fr > 0.5 || (fr == 0.5 && ip[0])) ip = ip + 1;
    if (ip == 25'd16777216) begin ip = 25'd8388608; e++; end
    if (e + 127 >= 255) return {sg, 8'hFF, 23'd0};
    if (e + 127 <= 0) return {sg, 31'd0};
    return {sg, 8'(e + 127), ip[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] c, input logic [7:0] s, output int stalls);
    in_codes = c; in_scale = s; in_valid = 1'b1; stalls = 0;
    #1;
    while (!in_ready) begin @(negedge clk); #1; stalls++; end
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic write_cfg(input logic [31:0] v);
    cfg_valid = 1'b1; cfg_scale = v;
    #1;
    while (!cfg_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    cfg_valid = 1'b0; cur_ts = v;
  endtask

  task automatic check_block(input string tag, input logic [63:0] c, input logic [7:0] s, input logic [31:0] t);
    int w = 0;
    #1;
    while (!out_valid && w < 20) begin @(negedge clk); #1; w++; end
    check({tag, " beat"}, {31'd0, out_valid}, 32'd1);
    for (int i = 0; i < 16; i++)
      check(tag, out_data[32*i +: 32], model(c[4*i +: 4], s, t));
    @(posedge clk); @(negedge clk);
  endtask

  function automatic string tag_for(input logic [7:0] s, input logic [31:0] t);
    if (s[6:0] == 7'h7F || t[30:23] == 8'hFF) return "R4";
    if (t[30:23] <= 8'h01 || t[30:23] >= 8'hF0) return "R6";
    if (s[6:3] == 4'd0) return "R2";
    return "R3";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int st;
    logic [31:0] held [16];
    repeat (3) @(negedge clk);
    #1;
    // R10: reset state
    check("R10", {31'd0, out_valid}, 32'd0);
    check("R10", {31'd0, in_ready}, 32'd1);
    check("R10", {31'd0, cfg_ready}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R10: default tensor scale 1.0; R5: code 0x8 gives -0.0
    send(SEQ, 8'h38, st);
    #1;
    check("R7", {31'd0, out_valid}, 32'd0);
    @(negedge clk); #1;
    check("R7", {31'd0, out_valid}, 32'd1);
    check("R10", out_data[32*2 +: 32], 32'h3F80_0000);
    check("R5", out_data[32*8 +: 32], 32'h8000_0000);
    check_block("R10", SEQ, 8'h38, 32'h3F80_0000);

    // R1: reversed lane order
    send(REV, 8'h40, st);
    check_block("R1", REV, 8'h40, cur_ts);

    // table walk: every code against each scale pair
    for (int k = 0; k < 15; k++) begin
      if (TV[k][39:8] != cur_ts) write_cfg(TV[k][39:8]);
      send(SEQ, TV[k][7:0], st);
      check_block(tag_for(TV[k][7:0], TV[k][39:8]), SEQ, TV[k][7:0], TV[k][39:8]);
    end
    write_cfg(32'h3F80_0000);

    // R8: backpressure holds the beat
    out_ready = 1'b0;
    send(SEQ, 8'h40, st);
    repeat (3) @(negedge clk);
    #1;
    for (int i = 0; i < 16; i++) held[i] = out_data[32*i +: 32];
    check("R8", {31'd0, out_valid}, 32'd1);
    check("R8", {31'd0, in_ready}, 32'd0);
    @(negedge clk); #1;
    for (int i = 0; i < 16; i++) check("R8", out_data[32*i +: 32], held[i]);

    // R9: scale write collides with the parked beat
    cfg_valid = 1'b1; cfg_scale = 32'h4000_0000;
    #1;
    check("R9", {31'd0, cfg_ready}, 32'd0);
    out_ready = 1'b1;
    #0.2;
    for (int i = 0; i < 16; i++) check("R9", out_data[32*i +: 32], model(SEQ[4*i +: 4], 8'h40, 32'h3F80_0000));
    @(posedge clk); @(negedge clk); #1;
    check("R9", {31'd0, out_valid}, 32'd0);
    check("R9", {31'd0, cfg_ready}, 32'd1);
    check("R9", {31'd0, in_ready}, 32'd0);
    @(posedge clk); @(negedge clk);
    cfg_valid = 1'b0; cur_ts = 32'h4000_0000;
    send(SEQ, 8'h38, st);
    check_block("R9", SEQ, 8'h38, 32'h4000_0000);

    // R11: back-to-back blocks, order kept
    fork
      begin
        int s0, s1, s2;
        send(SEQ, 8'h38, s0);
        send(REV, 8'h40, s1);
        send(SEQ, 8'h48, s2);
        check("R11", 32'(s0 + s1 + s2), 32'd0);
      end
      begin
        check_block("R11", SEQ, 8'h38, 32'h4000_0000);
        check_block("R11", REV, 8'h40, 32'h4000_0000);
        check_block("R11", SEQ, 8'h48, 32'h4000_0000);
      end
    join

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule